// File: doc/BRIEF.md
# CCM Header Block Formatter

This block produces the byte stream that opens a CCM authentication pass: first the sixteen-byte initial block B0, then the length prefix placed ahead of the associated data. A single start strobe hands it the nonce, the tag length t, the length-field size q, the payload length Q and the associated-data length a. The bytes then leave one per accepted cycle over a valid/ready handshake.

B0 begins with a flags byte that packs t, q and the presence of associated data. The nonce follows, and the last q bytes hold Q in big-endian order. Because q moves the nonce/length boundary, the nonce takes 15-q bytes. If Q cannot be held in q octets, the request is refused with an error pulse and nothing is emitted. The associated-data prefix comes in three sizes: none when a is zero, a short two-byte form, and a long six-byte form with a fixed marker.

The nonce input carries its first byte in bits [103:96], its second byte in bits [95:88], and so on. Nonce bytes beyond 15-q are unused.

Top module: `ccm_header_fmt`

## Requirements
- R1: A start strobe seen while idle captures every parameter input. Start strobes and input changes while a stream is in progress have no effect on the emitted bytes.
- R2: Byte 0 is the flags byte: bit 7 is 0, bit 6 is 1 exactly when a > 0, bits 5:3 hold (t-2)/2, and bits 2:0 hold q-1. The t input takes the even values 4 to 16 and the q input takes the values 2 to 8.
- R3: Bytes 1 through 15-q carry the nonce, with nonce byte 0 (input bits [103:96]) placed in byte 1.
- R4: Bytes 16-q through 15 carry Q in big-endian order, with its least significant octet in byte 15.
- R5: If Q >= 2^(8q), overflow_err pulses high for one cycle, in the cycle after the start edge, and no byte is offered. The block then stays idle.
- R6: When a = 0, exactly 16 bytes are emitted and out_last marks byte 15.
- R7: When 0 < a < 0xFF00, two prefix bytes follow B0: a[15:8] and then a[7:0].
- R8: When a >= 0xFF00, six prefix bytes follow B0: 0xFF, 0xFE, then a[31:0] in big-endian order.
- R9: While out_valid is high and out_ready is low, out_valid and out_data hold their values. Each accepted cycle advances the stream by exactly one byte, and out_last is high only on the final byte.
- R10: done is a one-cycle pulse in the cycle after the final byte is accepted, and out_valid is low in that cycle.
- R11: A start strobe in the same cycle as the acceptance of the final byte is ignored; no new stream begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture parameters and begin a stream |
| tag_octets | input | 5 | Tag length t in bytes |
| q_octets | input | 4 | Length-field size q in bytes |
| nonce | input | 104 | Nonce, first byte in the top octet |
| payload_len | input | 64 | Payload length Q |
| adata_len | input | 32 | Associated-data length a |
| out_valid | output | 1 | A byte is offered |
| out_ready | input | 1 | Consumer accepts the offered byte |
| out_data | output | 8 | Offered byte |
| out_last | output | 1 | Offered byte is the final one |
| done | output | 1 | Pulse after the final byte is accepted |
| overflow_err | output | 1 | Pulse when Q does not fit in q octets |

## Verification
The final-byte handshake and a new start strobe can land in the same cycle. The bench raises start together with the acceptance of the last byte. It also drives fresh parameters and a start strobe partway through a stream. It then checks that done follows, that out_valid stays low afterwards, and that the bytes already in flight still match the first request. It also uses stalled handshake patterns against the expected byte layouts, to confirm that a hold never skips or repeats a byte.

// File: rtl/ccm_hdr_pkg.sv
package ccm_hdr_pkg;

    localparam int NONCE_MAX = 13;
    localparam int BLK_BYTES = 16;
    localparam int LEN_W     = 64;
    localparam int AD_W      = 32;
    localparam int NONCE_W   = 8 * NONCE_MAX;
    localparam int PFX_LONG  = 6;
    localparam int PFX_SHORT = 2;
    localparam int MAX_BYTES = BLK_BYTES + PFX_LONG;
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam logic [AD_W-1:0] AD_LONG_MIN = 32'h0000_FF00;

    typedef enum logic [1:0] {PFX_NONE, PFX_TWO, PFX_SIX} pfx_kind_e;

    typedef struct packed {
        logic [NONCE_W-1:0] nonce;
        logic [LEN_W-1:0]   plen;
        logic [AD_W-1:0]    alen;
        logic [3:0]         q;
        logic [4:0]         t;
    } hdr_cfg_t;

    function automatic logic len_fits(input logic [LEN_W-1:0] plen, input logic [3:0] q);
        logic [LEN_W-1:0] rest;
        if (q >= 4'd8) return 1'b1;
        rest = plen >> (8 * int'(q));
        return (rest == '0);
    endfunction

    function automatic pfx_kind_e pfx_kind(input logic [AD_W-1:0] a);
        if (a == '0) return PFX_NONE;
        if (a < AD_LONG_MIN) return PFX_TWO;
        return PFX_SIX;
    endfunction

    function automatic logic [IDX_W-1:0] stream_last(input pfx_kind_e k);
        case (k)
            PFX_TWO: return IDX_W'(BLK_BYTES + PFX_SHORT - 1);
            PFX_SIX: return IDX_W'(BLK_BYTES + PFX_LONG - 1);
            default: return IDX_W'(BLK_BYTES - 1);
        endcase
    endfunction

endpackage

// File: rtl/ccm_hdr_b0.sv
module ccm_hdr_b0
    import ccm_hdr_pkg::*;
(
    input  hdr_cfg_t   cfg,
    input  logic [3:0] pos,
    output logic [7:0] byte_o
);
    logic [7:0]         flags;
    logic [NONCE_W-1:0] nshift;
    logic [LEN_W-1:0]   lshift;
    int                 nonce_end;
    int                 npos;
    int                 lpos;

    always_comb begin
        flags     = {1'b0, (cfg.alen != '0), 3'(({1'b0, cfg.t} - 6'd2) >> 1), 3'(cfg.q - 4'd1)};
        nonce_end = (BLK_BYTES - 1) - int'(cfg.q);
        npos      = NONCE_MAX - int'(pos);
        lpos      = (BLK_BYTES - 1) - int'(pos);
        nshift    = '0;
        lshift    = '0;
        if (pos == 4'd0) begin
            byte_o = flags;
        end else if (int'(pos) <= nonce_end) begin
            nshift = cfg.nonce >> (8 * npos);
            byte_o = nshift[7:0];
        end else begin
            lshift = cfg.plen >> (8 * lpos);
            byte_o = lshift[7:0];
        end
    end

    always_comb begin
        assert (!(pos == 4'd0) || byte_o[7] == 1'b0)
            else $error("assert_flags_top_bit_R2");
    end
endmodule

// File: rtl/ccm_hdr_adpfx.sv
module ccm_hdr_adpfx
    import ccm_hdr_pkg::*;
(
    input  logic [AD_W-1:0] alen,
    input  logic [2:0]      pos,
    output logic [7:0]      byte_o
);
    logic [AD_W-1:0] sh;

    always_comb begin
        sh = '0;
        if (pfx_kind(alen) == PFX_TWO) begin
            sh     = alen >> (8 * (PFX_SHORT - 1 - int'(pos)));
            byte_o = sh[7:0];
        end else if (pos == 3'd0) begin
            byte_o = 8'hFF;
        end else if (pos == 3'd1) begin
            byte_o = 8'hFE;
        end else begin
            sh     = alen >> (8 * (PFX_LONG - 1 - int'(pos)));
            byte_o = sh[7:0];
        end
    end
endmodule

// File: rtl/ccm_hdr_seq.sv
module ccm_hdr_seq
    import ccm_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go_ok,
    input  logic             go_bad,
    input  logic             ready,
    input  logic [IDX_W-1:0] last_idx,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output logic             ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            done <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            done <= 1'b0;
            ovf  <= 1'b0;
            if (!busy) begin
                if (go_ok) begin
                    busy <= 1'b1;
                    idx  <= '0;
                end else if (go_bad) begin
                    ovf <= 1'b1;
                end
            end else if (ready) begin
                if (idx == last_idx) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assert_idx_range_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> idx <= last_idx);
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        ovf |-> !busy);
    assert_done_after_last_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy && ready && idx == last_idx));
endmodule

// File: rtl/ccm_header_fmt.sv
module ccm_header_fmt
    import ccm_hdr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [4:0]         tag_octets,
    input  logic [3:0]         q_octets,
    input  logic [NONCE_W-1:0] nonce,
    input  logic [LEN_W-1:0]   payload_len,
    input  logic [AD_W-1:0]    adata_len,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data,
    output logic               out_last,
    output logic               done,
    output logic               overflow_err
);
    hdr_cfg_t         cfg;
    hdr_cfg_t         cfg_in;
    logic             busy;
    logic             fits_in;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [7:0]       b0_byte;
    logic [7:0]       pfx_byte;
    logic [IDX_W-1:0] pfx_pos;

    assign cfg_in  = '{nonce: nonce, plen: payload_len, alen: adata_len,
                       q: q_octets, t: tag_octets};
    assign fits_in = len_fits(payload_len, q_octets);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (!busy && start) begin
            cfg <= cfg_in;
        end
    end

    assign last_idx = stream_last(pfx_kind(cfg.alen));
    assign pfx_pos  = idx - IDX_W'(BLK_BYTES);

    ccm_hdr_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .go_ok    (start && fits_in),
        .go_bad   (start && !fits_in),
        .ready    (out_ready),
        .last_idx (last_idx),
        .busy     (busy),
        .idx      (idx),
        .done     (done),
        .ovf      (overflow_err)
    );

    ccm_hdr_b0 u_b0 (
        .cfg    (cfg),
        .pos    (idx[3:0]),
        .byte_o (b0_byte)
    );

    ccm_hdr_adpfx u_pfx (
        .alen   (cfg.alen),
        .pos    (pfx_pos[2:0]),
        .byte_o (pfx_byte)
    );

    assign out_valid = busy;
    assign out_data  = (idx < IDX_W'(BLK_BYTES)) ? b0_byte : pfx_byte;
    assign out_last  = busy && (idx == last_idx);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    assert_last_valid_R9: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
    assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) |-> $stable(cfg));
    assert_only_fitting_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> len_fits(cfg.plen, cfg.q));
    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);
endmodule

// File: tb/sim_ccm_header_fmt.sv
`timescale 1ns/1ps
module sim_ccm_header_fmt;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [4:0]   tag_octets = '0;
    logic [3:0]   q_octets = 4'd2;
    logic [103:0] nonce = '0;
    logic [63:0]  payload_len = '0;
    logic [31:0]  adata_len = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [7:0]   out_data;
    logic         out_last;
    logic         done;
    logic         overflow_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_b [0:21];
    int exp_n;

    always #4 clk = ~clk;

    ccm_header_fmt u0 (
        .clk(clk), .rst(rst), .start(start), .tag_octets(tag_octets),
        .q_octets(q_octets), .nonce(nonce), .payload_len(payload_len),
        .adata_len(adata_len), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .done(done),
        .overflow_err(overflow_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build_exp(input int t, input int q, input logic [103:0] n,
                             input logic [63:0] pl, input logic [31:0] a);
        logic [7:0] fl;
        fl = 8'h00;
        if (a != 0) fl[6] = 1'b1;
        fl[5:3] = 3'((t - 2) / 2);
        fl[2:0] = 3'(q - 1);
        exp_b[0] = fl;
        for (int i = 1; i <= 15 - q; i++) exp_b[i] = n[103 - 8*(i-1) -: 8];
        for (int k = 0; k < q; k++) exp_b[15 - k] = pl[8*k +: 8];
        exp_n = 16;
        if (a != 0 && a < 32'hFF00) begin
            exp_b[16] = a[15:8];
            exp_b[17] = a[7:0];
            exp_n = 18;
        end else if (a != 0) begin
            exp_b[16] = 8'hFF;
            exp_b[17] = 8'hFE;
            for (int k = 0; k < 4; k++) exp_b[18 + k] = a[31 - 8*k -: 8];
            exp_n = 22;
        end
    endtask

    task automatic kick(input int t, input int q, input logic [103:0] n,
                        input logic [63:0] pl, input logic [31:0] a);
        @(negedge clk);
        tag_octets = 5'(t); q_octets = 4'(q); nonce = n;
        payload_len = pl; adata_len = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // mode bit0: stall pattern; bit1: disturb inputs mid-stream and at last byte
    task automatic collect(input string req, input int mode);
        int got = 0;
        int cyc = 0;
        bit held = 0;
        logic [7:0] hv = '0;
        bit fin = 0;
        while (!fin && cyc < 100) begin
            out_ready = (mode & 1) ? ((cyc % 3) != 1) : 1'b1;
            if (held) begin
                chk(out_valid && out_data == hv, "R9 hold", {56'd0, out_data}, {56'd0, hv});
                held = 0;
            end
            if (out_valid && !out_ready) begin
                held = 1;
                hv = out_data;
            end
            if (out_valid && out_ready) begin
                chk(got < exp_n && out_data == exp_b[got], req, {56'd0, out_data},
                    {56'd0, exp_b[got]});
                chk(out_last == (got == exp_n - 1), "R9 last", 64'(out_last),
                    64'(got == exp_n - 1));
                if ((mode & 2) != 0 && (got == 2 || got == exp_n - 1)) begin
                    start = 1'b1; nonce = ~nonce; payload_len = 64'h1;
                    adata_len = 32'h0; q_octets = 4'd8; // R1 R11
                end
                if (got == exp_n - 1) fin = 1;
                got++;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk(got == exp_n, "R6 count", 64'(got), 64'(exp_n));
        chk(done == 1'b1, "R10 done", 64'(done), 64'd1);
        chk(out_valid == 1'b0, "R10 idle", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk(done == 1'b0 && out_valid == 1'b0, "R11 no restart",
            {62'd0, done, out_valid}, 64'd0);
        out_ready = 1'b0;
    endtask

    task automatic t_no_adata;
        build_exp(4, 2, 104'h0102030405060708090A0B0C0D, 64'h1234, 32'h0);
        kick(4, 2, 104'h0102030405060708090A0B0C0D, 64'h1234, 32'h0);
        chk(exp_b[0] == 8'h09, "R2 flags const", {56'd0, exp_b[0]}, 64'h09);
        collect("R2 R3 R4 R6 bytes", 0);
    endtask

    task automatic t_short_pfx;
        build_exp(16, 3, 104'hA1A2A3A4A5A6A7A8A9AAABACAD, 64'h00ABCDEF, 32'h20);
        kick(16, 3, 104'hA1A2A3A4A5A6A7A8A9AAABACAD, 64'h00ABCDEF, 32'h20);
        chk(exp_b[0] == 8'h7A, "R2 flags const", {56'd0, exp_b[0]}, 64'h7A);
        collect("R7 short prefix", 1);
    endtask

    task automatic t_long_pfx;
        build_exp(8, 8, 104'h112233445566778899AABBCCDD, 64'hFEDCBA9876543210, 32'hFF00);
        kick(8, 8, 104'h112233445566778899AABBCCDD, 64'hFEDCBA9876543210, 32'hFF00);
        collect("R8 long prefix q8", 1);
    endtask

    task automatic t_edge_pfx;
        build_exp(6, 2, 104'h5A5A5A5A5A5A5A5A5A5A5A5A5A, 64'hFFFF, 32'hFEFF);
        kick(6, 2, 104'h5A5A5A5A5A5A5A5A5A5A5A5A5A, 64'hFFFF, 32'hFEFF);
        collect("R7 R4 edge a=FEFF Q=FFFF", 0);
        build_exp(12, 5, 104'h0F1E2D3C4B5A69788796A5B4C3, 64'h00000012_3456789A, 32'h89ABCDEF);
        kick(12, 5, 104'h0F1E2D3C4B5A69788796A5B4C3, 64'h00000012_3456789A, 32'h89ABCDEF);
        collect("R8 large a", 0);
    endtask

    task automatic t_overflow;
        kick(4, 2, 104'h1, 64'h10000, 32'h5);
        chk(overflow_err == 1'b1, "R5 pulse", 64'(overflow_err), 64'd1);
        chk(out_valid == 1'b0, "R5 silent", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk(overflow_err == 1'b0 && out_valid == 1'b0, "R5 one cycle",
            {62'd0, overflow_err, out_valid}, 64'd0);
        kick(4, 7, 104'h1, 64'h0100_0000_0000_0000, 32'h0);
        chk(overflow_err == 1'b1 && out_valid == 1'b0, "R5 q7",
            {62'd0, overflow_err, out_valid}, 64'h2);
        @(negedge clk);
    endtask

    task automatic t_disturb;
        build_exp(10, 4, 104'hC0C1C2C3C4C5C6C7C8C9CACBCC, 64'hDEADBEEF, 32'h100);
        kick(10, 4, 104'hC0C1C2C3C4C5C6C7C8C9CACBCC, 64'hDEADBEEF, 32'h100);
        collect("R1 R11 frozen capture", 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && done == 1'b0 && overflow_err == 1'b0, "reset",
            {61'd0, out_valid, done, overflow_err}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        t_no_adata();
        t_short_pfx();
        t_long_pfx();
        t_edge_pfx();
        t_overflow();
        t_disturb();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule